// File: doc/BRIEF.md
# Operand Effective Address Generator

This block sits behind the opcode decoder of a small 8-bit processor. Once the decoder knows how an instruction addresses its operand, it pulses a start input with a two-bit addressing-mode code and the current index register value. The block then takes the operand bytes that follow the opcode from a byte stream with a valid/ready handshake, taking exactly as many bytes as the mode needs. It forms the 16-bit effective address and flags it with a one-cycle done strobe.

Four modes are supported. Two use absolute addresses: a short form with one byte that reaches only the bottom 256 locations, and a long form with two bytes that reaches the whole space. Two use the index register: one with no operand bytes at all, and one that adds an unsigned byte offset to the index. The offset sum keeps its carry into bit 8 and is never sign-extended, so it reaches at most 0x01FE. The high address byte is forced to zero in every mode except the long absolute form.

Top module: `oea_gen`

## Requirements
- R1: The mode code is captured when `start` is high while the block is idle, with 00 = short absolute, 01 = long absolute, 10 = index only, 11 = index plus byte offset. `index` is sampled in that same cycle, and later changes to `index` do not affect the result.
- R2: In short absolute mode one operand byte is taken, and the address is {0x00, byte}.
- R3: In long absolute mode two operand bytes are taken, the first as the high address byte and the second as the low address byte.
- R4: In index-only mode no operand byte is taken. `done` rises in the cycle after the start cycle, with the address {0x00, index}.
- R5: In index-plus-offset mode one byte is taken, and the address is the 9-bit unsigned sum of the index and the byte, zero-extended. Index 0xFF with offset 0xFF gives 0x01FE, and index 0x80 with offset 0x80 gives 0x0100.
- R6: A byte is consumed only in a cycle where `byte_valid` and `byte_ready` are both high. `byte_ready` is low while the block is idle and once the last needed byte has been taken. Valid bytes offered while idle have no effect.
- R7: `done` is high for exactly one cycle, in the cycle after the last byte is consumed (or after the start cycle for index-only mode). `addr` changes only together with `done` and holds its value until the next completion.
- R8: A `start` that arrives while operand bytes are still being collected is ignored. The fetch in progress completes with its original mode and index.
- R9: A synchronous active-high `rst` returns the block to idle and clears `addr` to 0 and `done` to 0, and it also abandons a fetch that is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address formation (taken only when idle) |
| mode | input | 2 | Addressing-mode code |
| index | input | BYTE_W | Index register value, sampled with start |
| byte_valid | input | 1 | Operand byte present on byte_data |
| byte_data | input | BYTE_W | Operand byte |
| byte_ready | output | 1 | Block will consume a byte this cycle |
| done | output | 1 | One-cycle strobe: addr is complete |
| addr | output | ADDR_W | Effective address |

## Verification
Every result is due one clock after its trigger edge. In index-only mode that is one cycle after the start edge, and in the other modes one cycle after the edge that consumes the last byte. `byte_ready` follows the fetch state, so it changes on the start edge and on the final-byte edge. A behavioural model in the bench, built on a byte queue, applies those same edge rules, and its done, address and ready values are compared with the ports at every falling edge, half a cycle after each update. The directed checks sample `done` and `addr` at the falling edge just after the consuming edge, and again one cycle later to confirm that the strobe has dropped and the address is held.

// File: rtl/oea_pkg.sv
package oea_pkg;

   typedef enum logic [1:0] {
      AM_DIR = 2'b00,
      AM_EXT = 2'b01,
      AM_IX0 = 2'b10,
      AM_IX8 = 2'b11
   } am_mode_e;

   localparam int unsigned MAX_OPERANDS = 2;

   function automatic logic [1:0] operand_count(am_mode_e m);
      case (m)
         AM_EXT:  return 2'd2;
         AM_IX0:  return 2'd0;
         default: return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/oea_fetch_ctl.sv
module oea_fetch_ctl
   import oea_pkg::*;
#(
   parameter int unsigned CNT_W = 2
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     start_i,
   input  am_mode_e mode_i,
   input  logic     byte_valid_i,
   output logic     byte_ready_o,
   output logic     latch_o,
   output logic     imm_o,
   output logic     accept_o,
   output logic     last_o
);

   generate
      if (CNT_W < $clog2(MAX_OPERANDS + 1)) begin : g_bad_cnt
         $error("oea_fetch_ctl: CNT_W too narrow for operand count");
      end
   endgenerate

   logic             busy_q;
   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] need;

   assign need         = CNT_W'(operand_count(mode_i));
   assign latch_o      = start_i & ~busy_q;
   assign imm_o        = latch_o & (need == '0);
   assign accept_o     = busy_q & byte_valid_i;
   assign last_o       = accept_o & (remain_q == CNT_W'(1));
   assign byte_ready_o = busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q   <= 1'b0;
         remain_q <= '0;
      end else if (latch_o && need != '0) begin
         busy_q   <= 1'b1;
         remain_q <= need;
      end else if (accept_o) begin
         remain_q <= remain_q - CNT_W'(1);
         if (last_o) busy_q <= 1'b0;
      end
   end

   // R6: ready drops once the final byte is consumed
   p_last_closes_r6: assert property (@(posedge clk) disable iff (rst)
      last_o |=> !byte_ready_o);

   // R1: a fetch only begins from a start pulse
   p_busy_from_start_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_q) |-> $past(start_i));

endmodule

// File: rtl/oea_addr_calc.sv
module oea_addr_calc
   import oea_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned ADDR_W = 16
) (
   input  am_mode_e          mode_i,
   input  logic [BYTE_W-1:0] index_i,
   input  logic [BYTE_W-1:0] hi_i,
   input  logic [BYTE_W-1:0] lo_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned SUM_W = BYTE_W + 1;

   generate
      if (ADDR_W < 2 * BYTE_W) begin : g_bad_addr
         $error("oea_addr_calc: ADDR_W must hold two operand bytes");
      end
   endgenerate

   logic [SUM_W-1:0] offs_sum;

   assign offs_sum = {1'b0, index_i} + {1'b0, lo_i};

   always_comb begin
      case (mode_i)
         AM_DIR:  addr_o = ADDR_W'(lo_i);
         AM_EXT:  addr_o = ADDR_W'({hi_i, lo_i});
         AM_IX0:  addr_o = ADDR_W'(index_i);
         default: addr_o = ADDR_W'(offs_sum);
      endcase
   end

endmodule

// File: rtl/oea_gen.sv
module oea_gen
   import oea_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [BYTE_W-1:0] index,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              byte_ready,
   output logic              done,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned CNT_W = $clog2(MAX_OPERANDS + 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("oea_gen: BYTE_W must be at least 2");
      end
   endgenerate

   am_mode_e          mode_in;
   am_mode_e          mode_q;
   am_mode_e          calc_mode;
   logic [BYTE_W-1:0] index_q;
   logic [BYTE_W-1:0] hi_q;
   logic [BYTE_W-1:0] calc_index;
   logic [ADDR_W-1:0] calc_addr;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q;
   logic              latch, imm, accept, last;

   assign mode_in = am_mode_e'(mode);

   oea_fetch_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk          (clk),
      .rst          (rst),
      .start_i      (start),
      .mode_i       (mode_in),
      .byte_valid_i (byte_valid),
      .byte_ready_o (byte_ready),
      .latch_o      (latch),
      .imm_o        (imm),
      .accept_o     (accept),
      .last_o       (last)
   );

   assign calc_mode  = imm ? mode_in : mode_q;
   assign calc_index = imm ? index   : index_q;

   oea_addr_calc #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_calc (
      .mode_i  (calc_mode),
      .index_i (calc_index),
      .hi_i    (hi_q),
      .lo_i    (byte_data),
      .addr_o  (calc_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= AM_DIR;
         index_q <= '0;
         hi_q    <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (latch) begin
            mode_q  <= mode_in;
            index_q <= index;
         end
         if (accept && !last) hi_q <= byte_data;
         if (imm || last) begin
            addr_q <= calc_addr;
            done_q <= 1'b1;
         end
      end
   end

   assign done = done_q;
   assign addr = addr_q;

   // R7: done is a single-cycle strobe
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R7: address only moves together with done
   p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !done |-> addr == $past(addr));

   // R5: offset sum never reaches above bit 8
   p_ix8_range_r5: assert property (@(posedge clk) disable iff (rst)
      (done && mode_q == AM_IX8) |-> (addr >> (BYTE_W + 1)) == '0);

   // R2: short absolute keeps a zero high part
   p_dir_high_r2: assert property (@(posedge clk) disable iff (rst)
      (done && mode_q == AM_DIR) |-> (addr >> BYTE_W) == '0);

   // R4: index-only result equals the sampled index
   p_ix0_value_r4: assert property (@(posedge clk) disable iff (rst)
      (done && mode_q == AM_IX0) |-> addr == ADDR_W'(index_q));

   // R8: start while fetching leaves the captured mode alone
   p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
      (byte_ready && start) |=> mode_q == $past(mode_q));

   // R9: reset clears outputs and fetch state
   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!done && addr == '0 && !byte_ready));

endmodule

// File: tb/tb_oea_gen.sv
module tb_oea_gen;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  index = 8'h00;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h00;
   logic        byte_ready;
   logic        done;
   logic [15:0] addr;

   always #5 clk = ~clk;

   oea_gen dut (
      .clk(clk), .rst(rst), .start(start), .mode(mode), .index(index),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .byte_ready(byte_ready), .done(done), .addr(addr)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    cmp_en = 1'b0;
   string cur_req = "R9";

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   bit         m_busy = 0;
   bit         m_done = 0;
   int         m_addr = 0;
   int         m_need = 0;
   int         m_mode = 0;
   int         m_idx  = 0;
   logic [7:0] m_q[$];

   always @(posedge clk) begin
      if (rst) begin
         m_busy = 0; m_done = 0; m_addr = 0; m_q.delete();
      end else begin
         m_done = 0;
         if (!m_busy) begin
            if (start) begin
               m_mode = mode; m_idx = index; m_q.delete();
               if (mode == 2) begin
                  m_addr = m_idx; m_done = 1;
               end else begin
                  m_busy = 1; m_need = (mode == 1) ? 2 : 1;
               end
            end
         end else if (byte_valid) begin
            m_q.push_back(byte_data);
            if (m_q.size() == m_need) begin
               case (m_mode)
                  0: m_addr = m_q[0];
                  1: m_addr = m_q[0] * 256 + m_q[1];
                  default: m_addr = m_q[0] + m_idx;
               endcase
               m_done = 1; m_busy = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !rst) begin
         check(cur_req, "model done", done, m_done);
         check(cur_req, "model addr", addr, m_addr);
         check("R6", "model ready", byte_ready, m_busy);
      end
   end

   task automatic do_start(logic [1:0] m, logic [7:0] idx);
      start = 1'b1; mode = m; index = idx;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] b);
      logic rdy;
      byte_valid = 1'b1; byte_data = b;
      forever begin
         rdy = byte_ready;
         @(negedge clk);
         if (rdy) break;
      end
      byte_valid = 1'b0;
   endtask

   task automatic expect_done(logic [15:0] exp, string req);
      int n = 0;
      while (!done && n < 10) begin @(negedge clk); n++; end
      check(req, "done seen", done, 1);
      check(req, "addr", addr, exp);
      check("R6", "ready low at done", byte_ready, 0);
      @(negedge clk);
      check("R7", "done pulse ends", done, 0);
      check("R7", "addr held", addr, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      check("R9", "reset done", done, 0);
      check("R9", "reset addr", addr, 0);
      check("R9", "reset ready", byte_ready, 0);
      cmp_en = 1'b1;

      cur_req = "R2";
      do_start(2'b00, 8'h33); send_byte(8'h7A); expect_done(16'h007A, "R2");

      cur_req = "R3";
      do_start(2'b01, 8'h00); send_byte(8'h12); send_byte(8'h34); expect_done(16'h1234, "R3");
      do_start(2'b01, 8'h00); send_byte(8'hFF); send_byte(8'hFF); expect_done(16'hFFFF, "R3");

      cur_req = "R4";
      do_start(2'b10, 8'hC5);
      check("R4", "done cycle after start", done, 1);
      expect_done(16'h00C5, "R4");

      cur_req = "R5";
      do_start(2'b11, 8'h10); send_byte(8'h20); expect_done(16'h0030, "R5");
      do_start(2'b11, 8'hFF); send_byte(8'hFF); expect_done(16'h01FE, "R5");
      do_start(2'b11, 8'h80); send_byte(8'h80); expect_done(16'h0100, "R5");

      cur_req = "R6";
      byte_valid = 1'b1; byte_data = 8'h99;
      repeat (3) @(negedge clk);
      byte_valid = 1'b0;
      check("R6", "idle byte no done", done, 0);
      check("R6", "idle byte addr kept", addr, 16'h0100);
      do_start(2'b00, 8'h00);
      repeat (3) @(negedge clk);
      check("R6", "no valid no done", done, 0);
      send_byte(8'h44); expect_done(16'h0044, "R6");

      cur_req = "R8";
      do_start(2'b01, 8'h00);
      do_start(2'b10, 8'h55);
      check("R8", "ignored start no done", done, 0);
      check("R8", "still fetching", byte_ready, 1);
      send_byte(8'hAB); send_byte(8'hCD); expect_done(16'hABCD, "R8");

      cur_req = "R1";
      do_start(2'b11, 8'h05);
      index = 8'hF0;
      send_byte(8'h01); expect_done(16'h0006, "R1");

      cur_req = "R9";
      do_start(2'b01, 8'h00); send_byte(8'h77);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check("R9", "mid reset done", done, 0);
      check("R9", "mid reset addr", addr, 0);
      check("R9", "mid reset ready", byte_ready, 0);
      cur_req = "R2";
      do_start(2'b00, 8'h00); send_byte(8'h11); expect_done(16'h0011, "R2");

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule